// File: doc/BRIEF.md
# Stack Call and Return Unit

This unit runs a descending stack held in a byte-addressed memory. It serves four commands: save a register value, restore a register value, enter a subroutine (save the instruction pointer and branch to an already fetched target) and leave a subroutine (restore the instruction pointer). Each element travels one byte per clock, least significant byte at the lowest address.

The element size depends on the command. Register saves and restores follow the current data width. Subroutine entry and exit follow the current address width, with the instruction pointer cut down to that width on entry and widened with zeros on exit. A width code of 0, 1, 2 or 3 selects 1, 2, 4 or 8 bytes. The stack pointer is as wide as the memory index, so it wraps around the memory size. Its reset value of zero stands for "memory size", which means the first save lands in the top byte.

The surrounding core offers a command when `cmd_ready` is high. It then watches `done`, which marks the cycle carrying the last byte. In that same cycle the restored register or instruction pointer appears together with its write enable.

Top module: `stk_call_unit`

## Requirements
- R1: After reset `sp` reads 0 (the memory size, modulo the memory size), `busy` is low and `cmd_ready` is high.
- R2: A push (cmd_op 0) lowers `sp` by the data-width byte count in the cycle after acceptance. It then writes the register value to addresses new_sp, new_sp+1, ..., one byte per cycle, least significant byte first.
- R3: A pop (cmd_op 1) reads bytes from sp upward, least significant first. In the last byte cycle it pulses `reg_wr_en` with the value zero-extended to 64 bits on `reg_wr_data`. From the next cycle `sp` is higher by the byte count.
- R4: A call (cmd_op 2) pushes `ip_in` truncated to the address width, the same way as R2. In its last byte cycle it pulses `ip_wr_en` with `ip_out` equal to the `call_target` captured at acceptance.
- R5: A return (cmd_op 3) reads address-width bytes from sp. In its last byte cycle it pulses `ip_wr_en` with `ip_out` equal to the zero-extended value truncated to IP_W bits. From the next cycle `sp` is higher by the byte count.
- R6: Width code c (0..3) gives 2^c bytes. Push and pop use `data_width`; call and return use `addr_width`.
- R7: Stack pointer and memory addresses wrap modulo MEM_BYTES in both directions.
- R8: An accepted command keeps `busy` high for exactly as many cycles as it moves bytes, with `done` high only in the last. `cmd_valid` is ignored while busy.
- R9: `mem_we` and `mem_re` are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted |
| cmd_op | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| data_width | input | 2 | Data width code for push/pop |
| addr_width | input | 2 | Address width code for call/return |
| reg_rd_data | input | 64 | Register value to push |
| ip_in | input | IP_W | Instruction pointer past the call operand |
| call_target | input | IP_W | Fetched call destination |
| reg_wr_en | output | 1 | Popped value valid |
| reg_wr_data | output | 64 | Popped value, zero-extended |
| ip_wr_en | output | 1 | New instruction pointer valid |
| ip_out | output | IP_W | New instruction pointer |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_addr | output | log2(MEM_BYTES) | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the same cycle as mem_addr |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last byte cycle |
| sp | output | log2(MEM_BYTES) | Stack pointer |

## Verification
The command is accepted at one clock edge. The first byte is on the memory port in the following cycle, and with n bytes `done` rises in the n-th cycle after acceptance. Pop and return results are due in that same cycle, and the settled stack pointer and idle state one cycle later. The bench drives on falling edges and samples on falling edges. It counts the cycles from acceptance to `done` and compares that count with n. It reads the results in the `done` cycle, and checks `sp`, `busy` and the memory bytes one falling edge after `done`, against a byte-level model of the stack.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [1:0] {
      STK_PUSH = 2'd0,
      STK_POP  = 2'd1,
      STK_CALL = 2'd2,
      STK_RET  = 2'd3
   } stk_op_e;

   localparam int unsigned STK_MAX_BYTES = 8;
   localparam int unsigned STK_VAL_W     = 8 * STK_MAX_BYTES;

   // bytes moved for a width code: 1, 2, 4, 8
   function automatic logic [3:0] stk_width_bytes(input logic [1:0] code);
      return 4'd1 << code;
   endfunction

   function automatic logic stk_is_write(input stk_op_e op);
      return (op == STK_PUSH) || (op == STK_CALL);
   endfunction

endpackage

// File: rtl/stk_sp.sv
module stk_sp #(
   parameter int unsigned SP_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dec_en,
   input  logic            inc_en,
   input  logic [3:0]      step,
   output logic [SP_W-1:0] sp
);
   logic [SP_W-1:0] step_ext;
   assign step_ext = SP_W'(step);

   // zero encodes the full memory size; arithmetic wraps naturally (R7)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp <= '0;
      else if (dec_en)
         sp <= sp - step_ext;
      else if (inc_en)
         sp <= sp + step_ext;
   end

   p_sp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_en && inc_en));

endmodule

// File: rtl/stk_byte_seq.sv
module stk_byte_seq #(
   parameter int unsigned MAXB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        nbytes,
   input  logic [8*MAXB-1:0] wvalue,
   input  logic [7:0]        rbyte,
   output logic              busy,
   output logic              last,
   output logic [2:0]        cnt,
   output logic [3:0]        n_len,
   output logic [7:0]        wbyte,
   output logic [8*MAXB-1:0] rvalue
);
   logic [8*MAXB-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         n_len <= 4'd1;
         shreg <= '0;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         cnt   <= '0;
         n_len <= nbytes;
         shreg <= wvalue;
      end else if (busy) begin
         shreg <= shreg >> 8;
         if (last) busy <= 1'b0;
         else      cnt  <= cnt + 3'd1;
      end
   end

   assign last  = busy && ({1'b0, cnt} == (n_len - 4'd1));
   assign wbyte = shreg[7:0];

   // one capture lane per byte; lanes cleared on start stay zero (zero-extend)
   for (genvar i = 0; i < MAXB; i++) begin : g_lane
      logic [7:0] acc;
      logic       hit;
      assign hit = busy && (cnt == 3'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                acc <= '0;
         else if (start && !busy)   acc <= '0;
         else if (hit)              acc <= rbyte;
      end
      assign rvalue[8*i +: 8] = hit ? rbyte : acc;
   end

   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ({1'b0, cnt} < n_len));
   p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !busy);

endmodule

// File: rtl/stk_call_unit.sv
module stk_call_unit #(
   parameter int unsigned MEM_BYTES = 256,
   parameter int unsigned IP_W      = 16,
   localparam int unsigned SP_W     = $clog2(MEM_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   output logic            cmd_ready,
   input  logic [1:0]      cmd_op,
   input  logic [1:0]      data_width,
   input  logic [1:0]      addr_width,
   input  logic [63:0]     reg_rd_data,
   input  logic [IP_W-1:0] ip_in,
   input  logic [IP_W-1:0] call_target,
   output logic            reg_wr_en,
   output logic [63:0]     reg_wr_data,
   output logic            ip_wr_en,
   output logic [IP_W-1:0] ip_out,
   output logic            mem_we,
   output logic            mem_re,
   output logic [SP_W-1:0] mem_addr,
   output logic [7:0]      mem_wdata,
   input  logic [7:0]      mem_rdata,
   output logic            busy,
   output logic            done,
   output logic [SP_W-1:0] sp
);
   import stk_pkg::*;

   if ((MEM_BYTES & (MEM_BYTES - 1)) != 0 || MEM_BYTES < 16) begin : g_bad_mem
      $error("MEM_BYTES must be a power of two of at least 16");
   end
   if (IP_W < 1 || IP_W > STK_VAL_W) begin : g_bad_ip
      $error("IP_W must lie in 1..64");
   end

   stk_op_e           op_in, op_q;
   logic              accept, last;
   logic [3:0]        n_sel, n_len;
   logic [2:0]        cnt;
   logic [63:0]       wvalue, rvalue;
   logic [SP_W-1:0]   base_q;
   logic [IP_W-1:0]   target_q;

   assign op_in  = stk_op_e'(cmd_op);
   assign accept = cmd_valid && !busy;
   assign n_sel  = (op_in == STK_PUSH || op_in == STK_POP)
                   ? stk_width_bytes(data_width) : stk_width_bytes(addr_width);
   // only the low n bytes are shifted out, so truncation is implicit
   assign wvalue = (op_in == STK_PUSH) ? reg_rd_data : 64'(ip_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q     <= STK_PUSH;
         base_q   <= '0;
         target_q <= '0;
      end else if (accept) begin
         op_q     <= op_in;
         target_q <= call_target;
         base_q   <= stk_is_write(op_in) ? (sp - SP_W'(n_sel)) : sp;
      end
   end

   stk_sp #(.SP_W(SP_W)) u_sp (
      .clk    (clk),
      .rst_n  (rst_n),
      .dec_en (accept && stk_is_write(op_in)),
      .inc_en (last && !stk_is_write(op_q)),
      .step   (accept ? n_sel : n_len),
      .sp     (sp)
   );

   stk_byte_seq #(.MAXB(STK_MAX_BYTES)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .nbytes (n_sel),
      .wvalue (wvalue),
      .rbyte  (mem_rdata),
      .busy   (busy),
      .last   (last),
      .cnt    (cnt),
      .n_len  (n_len),
      .wbyte  (mem_wdata),
      .rvalue (rvalue)
   );

   assign cmd_ready   = !busy;
   assign done        = last;
   assign mem_addr    = base_q + SP_W'(cnt);
   assign mem_we      = busy && stk_is_write(op_q);
   assign mem_re      = busy && !stk_is_write(op_q);
   assign reg_wr_en   = last && (op_q == STK_POP);
   assign reg_wr_data = rvalue;
   assign ip_wr_en    = last && (op_q == STK_CALL || op_q == STK_RET);
   assign ip_out      = (op_q == STK_CALL) ? target_q : rvalue[IP_W-1:0];

   p_rw_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re));
   p_pop_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (done && !ip_wr_en));
   p_ip_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ip_wr_en |-> done);
   p_push_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_in == STK_PUSH) |=> (sp == $past(sp) - SP_W'($past(n_sel))));
   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> $stable(op_q));

endmodule

// File: tb/tb_stk_call_unit.sv
`timescale 1ns/1ps
module tb_stk_call_unit;
   localparam int M    = 256;
   localparam int IPW  = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_valid = 1'b0;
   logic            cmd_ready;
   logic [1:0]      cmd_op = '0, data_width = '0, addr_width = '0;
   logic [63:0]     reg_rd_data = '0;
   logic [IPW-1:0]  ip_in = '0, call_target = '0;
   logic            reg_wr_en, ip_wr_en, mem_we, mem_re, busy, done;
   logic [63:0]     reg_wr_data;
   logic [IPW-1:0]  ip_out;
   logic [7:0]      mem_addr, sp, mem_wdata, mem_rdata;

   logic [7:0] mem [M];
   logic [7:0] ref_mem [M];
   int ref_sp = 0;
   int tests = 0, fails = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   stk_call_unit #(.MEM_BYTES(M), .IP_W(IPW)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .data_width(data_width), .addr_width(addr_width),
      .reg_rd_data(reg_rd_data), .ip_in(ip_in), .call_target(call_target),
      .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .ip_wr_en(ip_wr_en),
      .ip_out(ip_out), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .sp(sp));

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int nbytes(input logic [1:0] c);
      return 1 << c;
   endfunction

   // op: 0 push 1 pop 2 call 3 ret; inject offers a second command while busy
   task automatic do_op(input logic [1:0] op, input logic [1:0] dw, input logic [1:0] aw,
                        input logic [63:0] val, input logic [IPW-1:0] ipv,
                        input logic [IPW-1:0] tgt, input bit inject);
      int n, cyc, base;
      logic [63:0] v, exp;
      bit seen_done;
      logic got_reg_en, got_ip_en;
      logic [63:0] got_reg;
      logic [IPW-1:0] got_ip;
      n = (op < 2) ? nbytes(dw) : nbytes(aw);
      exp = '0;
      if (op == 0 || op == 2) begin
         v = (op == 0) ? val : 64'(ipv);
         ref_sp = (ref_sp - n) & (M - 1);
         for (int k = 0; k < n; k++) ref_mem[(ref_sp + k) % M] = v[8*k +: 8];
      end else begin
         for (int k = 0; k < n; k++) exp[8*k +: 8] = ref_mem[(ref_sp + k) % M];
      end
      base = ref_sp;
      if (op == 1 || op == 3) ref_sp = (ref_sp + n) & (M - 1);

      @(negedge clk);
      cmd_op = op; data_width = dw; addr_width = aw;
      reg_rd_data = val; ip_in = ipv; call_target = tgt; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      reg_rd_data = ~val; ip_in = ~ipv; call_target = ~tgt;
      cyc = 1; seen_done = 0;
      got_reg_en = 0; got_ip_en = 0; got_reg = '0; got_ip = '0;
      while (!seen_done && cyc <= 10) begin
         if (inject && cyc == 1) begin
            chk(cmd_ready == 1'b0, "R8 ready low while busy", 64'(cmd_ready), 0);
            cmd_op = 2'd1; data_width = 2'd3; cmd_valid = 1'b1;
         end else cmd_valid = 1'b0;
         if (done) begin
            seen_done = 1;
            got_reg_en = reg_wr_en; got_reg = reg_wr_data;
            got_ip_en = ip_wr_en; got_ip = ip_out;
         end else begin
            @(negedge clk);
            cyc++;
         end
      end
      cmd_valid = 1'b0;
      chk(seen_done && cyc == n, "R8 done after n byte cycles", 64'(cyc), 64'(n));
      case (op)
         2'd0: chk(!got_reg_en && !got_ip_en, "R2 no writeback on push",
                   64'({got_reg_en, got_ip_en}), 0);
         2'd1: chk(got_reg_en && !got_ip_en && got_reg == exp, "R3 pop value",
                   got_reg, exp);
         2'd2: chk(got_ip_en && got_ip == tgt, "R4 call branches to target",
                   64'(got_ip), 64'(tgt));
         default: chk(got_ip_en && got_ip == exp[IPW-1:0], "R5 return ip",
                   64'(got_ip), 64'(exp[IPW-1:0]));
      endcase
      @(negedge clk);
      chk(sp == ref_sp[7:0], "R7 sp after command", 64'(sp), 64'(ref_sp));
      chk(!busy, "R8 idle after done", 64'(busy), 0);
      if (op == 0 || op == 2)
         for (int k = 0; k < n; k++)
            chk(mem[(base + k) % M] == ref_mem[(base + k) % M],
                (op == 0) ? "R2 pushed byte" : "R4 saved ip byte",
                64'(mem[(base + k) % M]), 64'(ref_mem[(base + k) % M]));
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < M; i++) begin mem[i] = 8'h00; ref_mem[i] = 8'h00; end
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(sp == 8'd0 && !busy && cmd_ready, "R1 reset state",
          64'({sp, busy, cmd_ready}), 64'h1);
      chk(!mem_we && !mem_re, "R9 idle memory quiet", 64'({mem_we, mem_re}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1/R7: first byte lands at the top address
      do_op(2'd0, 2'd0, 2'd0, 64'hA5, '0, '0, 0);
      chk(mem[M-1] == 8'hA5, "R1 first push at top", 64'(mem[M-1]), 64'hA5);
      // R6 widths
      do_op(2'd0, 2'd3, 2'd0, 64'h0123_4567_89AB_CDEF, '0, '0, 0);
      do_op(2'd1, 2'd3, 2'd0, '0, '0, '0, 0);
      do_op(2'd0, 2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_BEEF, '0, '0, 0);
      do_op(2'd1, 2'd1, 2'd0, '0, '0, '0, 0);
      do_op(2'd1, 2'd0, 2'd0, '0, '0, '0, 0);
      // R7: pop past the top wraps to address 0
      do_op(2'd1, 2'd2, 2'd0, '0, '0, '0, 0);
      do_op(2'd0, 2'd2, 2'd0, 64'h1122_3344, '0, '0, 0);
      // R4/R5 call and return at several address widths
      do_op(2'd2, 2'd0, 2'd1, '0, 16'h1234, 16'h0040, 0);
      do_op(2'd3, 2'd0, 2'd1, '0, '0, '0, 0);
      do_op(2'd2, 2'd0, 2'd0, '0, 16'hBEEF, 16'h0100, 0);
      do_op(2'd3, 2'd0, 2'd0, '0, '0, '0, 0);
      do_op(2'd2, 2'd0, 2'd3, '0, 16'hCAFE, 16'h7777, 0);
      do_op(2'd3, 2'd0, 2'd3, '0, '0, '0, 0);
      // R8: second command while busy is ignored
      do_op(2'd0, 2'd3, 2'd0, 64'hDEAD_BEEF_0BAD_F00D, '0, '0, 1);
      do_op(2'd1, 2'd3, 2'd0, '0, '0, '0, 0);
      for (int i = 0; i < 400; i++) begin
         do_op(2'($urandom % 4), 2'($urandom % 4), 2'($urandom % 4),
               {$urandom, $urandom}, 16'($urandom), 16'($urandom), ($urandom % 8) == 0);
      end
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule